// File: doc/BRIEF.md
# Reverse-Channel Byte Receiver with Run-Length Expansion

This block is the host side of an enhanced-mode parallel link while the peripheral sends data back to the host. When the link is still pointed forward, the block first turns the bus around. It then takes bytes one at a time with a two-phase handshake. The busy line, sampled with each byte, tells data bytes apart from command bytes. A command byte either carries a run-length count or names a channel. A count makes the next data byte come out several times. A channel address is thrown away. Expanded bytes leave on a valid/ready stream. The block can also hand the bus back to the forward direction when asked.

The host side sets `rx_en` to receive and pulses or holds `fwd_req` to turn the link back to forward. All timing is counted in ticks of `TICK_DIV` clock cycles. The peripheral inputs pass through a synchronizer before they are used. Each handshake wait is bounded. When a wait runs out, `link_error` is set and the block goes idle. The error stays set, and it blocks new work, until both requests are withdrawn.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset all four control outputs are high, `link_reverse` is 0, `link_error` is 0 and `m_valid` is 0.
- R2: When `rx_en` is set while the link is forward, `host_autofd_n` falls first while `host_init_n` stays high for `SETUP_TICKS` ticks. Then `host_init_n` falls. Once `per_perror` is seen low, `link_reverse` becomes 1. `host_strobe_n` and `host_selin_n` stay high throughout.
- R3: If `per_perror` stays high for `RESP_TICKS` ticks during the turnaround to reverse, `link_error` is set, `link_reverse` stays 0 and all control outputs return high.
- R4: A byte taken while `per_busy` is high (data byte) appears on `m_data` with its value unchanged.
- R5: After a byte is taken on `per_ack_n` low, `host_autofd_n` rises. After `per_ack_n` is seen high again, `host_autofd_n` falls, which signals readiness for the next byte.
- R6: A command byte (`per_busy` low) with bit 7 = 1 is a channel address. It produces no output and leaves any pending run count unchanged.
- R7: A command byte with bit 7 = 0 stores its low 7 bits as a count N. The next data byte is output N+1 times in total. The count then goes back to 0, so later data bytes come out once.
- R8: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_data` hold. Pending repeats go on after the stall, and none are lost.
- R9: A new bus byte is not taken while the output still holds undelivered copies: `host_autofd_n` stays low even with `per_ack_n` low.
- R10: If `per_ack_n` does not return high within `RESP_TICKS` ticks after a byte is taken, `link_error` is set, the block goes idle and `link_reverse` stays 1.
- R11: When `fwd_req` is set in reverse, `host_init_n` rises while `host_autofd_n` stays low. Once `per_perror` is seen high, `host_autofd_n` rises and `link_reverse` becomes 0.
- R12: While `link_error` is 1 and either `rx_en` or `fwd_req` is set, the error holds and no control output moves. The error clears once both are low.
- R13: If `per_ack_n` stays high for `IDLE_TICKS` ticks while the block waits for a byte, `link_error` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Level request to receive in reverse |
| fwd_req | input | 1 | Level request to return the link to forward; has priority over rx_en |
| per_ack_n | input | 1 | Peripheral byte strobe, active low |
| per_busy | input | 1 | High for data byte, low for command byte |
| per_perror | input | 1 | Peripheral acknowledge of bus direction change |
| per_data | input | DATA_W | Byte driven by the peripheral |
| host_autofd_n | output | 1 | Host acknowledge / reverse request line |
| host_init_n | output | 1 | Host direction request line |
| host_strobe_n | output | 1 | Host strobe, held high |
| host_selin_n | output | 1 | Host select line, held high |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the byte |
| m_data | output | DATA_W | Output byte |
| link_reverse | output | 1 | 1 when the link points from peripheral to host |
| link_error | output | 1 | Sticky handshake timeout flag |

## Verification
The assertions assume the downstream side may hold `m_ready` low for any length of time. They also assume the peripheral changes `per_data` and `per_busy` only while `per_ack_n` is high, so a byte is stable through the synchronizer when it is taken. The bench drives the peripheral lines only after seeing the host line they answer, and it sets up data and busy one cycle before lowering `per_ack_n`. It changes `m_ready` just after a rising edge and samples the stream at the falling edge.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REV_HOLD,
    ST_REV_PE,
    ST_WAIT_BYTE,
    ST_WAIT_REL,
    ST_FWD_PE
  } link_st_e;

  typedef struct packed {
    logic autofd_n;
    logic init_n;
    logic strobe_n;
    logic selin_n;
  } ctl_pins_t;

  // Control line levels for a given state and direction.
  function automatic ctl_pins_t pins_for(link_st_e st, logic rev);
    ctl_pins_t p;
    p.strobe_n = 1'b1;
    p.selin_n  = 1'b1;
    unique case (st)
      ST_REV_HOLD: begin p.autofd_n = 1'b0; p.init_n = 1'b1; end
      ST_REV_PE:   begin p.autofd_n = 1'b0; p.init_n = 1'b0; end
      ST_WAIT_REL: begin p.autofd_n = 1'b1; p.init_n = 1'b0; end
      ST_FWD_PE:   begin p.autofd_n = 1'b0; p.init_n = 1'b1; end
      default: begin
        p.autofd_n = ~rev;
        p.init_n   = ~rev;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ecp_pin_sync.sv
module ecp_pin_sync #(
  parameter int          W       = 11,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ecp_wait_timer.sv
module ecp_wait_timer #(
  parameter int TICK_DIV  = 4,
  parameter int MAX_TICKS = 2000,
  localparam int CW = $clog2(MAX_TICKS + 1),
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_q == PW'(TICK_DIV - 1)) begin
      pre_q <= '0;
      if (cnt_q != CW'(MAX_TICKS)) cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/ecp_run_expander.sv
module ecp_run_expander #(
  parameter int DATA_W = 8,
  localparam int RUN_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_is_data,
  input  logic [DATA_W-1:0] push_byte,
  output logic              free,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  logic              val_q;
  logic [DATA_W-1:0] dat_q;
  logic [RUN_W-1:0]  rep_q;   // copies still owed after the current one
  logic [RUN_W-1:0]  run_q;   // count waiting for the next data byte
  logic              pop;

  assign pop  = val_q && m_ready;
  assign free = !val_q || (m_ready && rep_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= 1'b0;
      dat_q <= '0;
      rep_q <= '0;
      run_q <= '0;
    end else begin
      if (pop) begin
        if (rep_q != '0) rep_q <= rep_q - 1'b1;
        else             val_q <= 1'b0;
      end
      if (push && push_is_data) begin
        val_q <= 1'b1;
        dat_q <= push_byte;
        rep_q <= run_q;
        run_q <= '0;
      end else if (push && !push_byte[DATA_W-1]) begin
        run_q <= push_byte[RUN_W-1:0];
      end
    end
  end

  assign m_valid = val_q;
  assign m_data  = dat_q;
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx #(
  parameter int DATA_W      = 8,
  parameter int TICK_DIV    = 4,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              fwd_req,
  input  logic              per_ack_n,
  input  logic              per_busy,
  input  logic              per_perror,
  input  logic [DATA_W-1:0] per_data,
  output logic              host_autofd_n,
  output logic              host_init_n,
  output logic              host_strobe_n,
  output logic              host_selin_n,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              link_reverse,
  output logic              link_error
);
  import ecp_rx_pkg::*;

  localparam int T_A  = (SETUP_TICKS > RESP_TICKS) ? SETUP_TICKS : RESP_TICKS;
  localparam int TMAX = (IDLE_TICKS > T_A) ? IDLE_TICKS : T_A;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int SW   = DATA_W + 3;

  // Synchronized peripheral lines
  logic [SW-1:0]     sync_q;
  logic              ack_s, busy_s, perr_s;
  logic [DATA_W-1:0] data_s;

  ecp_pin_sync #(
    .W(SW), .STAGES(SYNC_STAGES),
    .RST_VAL({1'b1, 1'b0, 1'b1, {DATA_W{1'b0}}})
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({per_ack_n, per_busy, per_perror, per_data}),
    .q(sync_q)
  );
  assign {ack_s, busy_s, perr_s, data_s} = sync_q;

  link_st_e  st_q, st_d;
  logic      dir_q, dir_d;
  logic      err_q, err_d;
  ctl_pins_t pin_q;
  logic      take, exp_free, expired;
  logic [CW-1:0] limit;

  always_comb begin
    unique case (st_q)
      ST_REV_HOLD:  limit = CW'(SETUP_TICKS);
      ST_WAIT_BYTE: limit = CW'(IDLE_TICKS);
      default:      limit = CW'(RESP_TICKS);
    endcase
  end

  ecp_wait_timer #(.TICK_DIV(TICK_DIV), .MAX_TICKS(TMAX)) u_timer (
    .clk(clk), .rst(rst), .restart(st_d != st_q),
    .limit(limit), .expired(expired)
  );

  assign take = (st_q == ST_WAIT_BYTE) && rx_en && !ack_s && exp_free;

  ecp_run_expander #(.DATA_W(DATA_W)) u_exp (
    .clk(clk), .rst(rst),
    .push(take), .push_is_data(busy_s), .push_byte(data_s),
    .free(exp_free),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  always_comb begin
    st_d  = st_q;
    dir_d = dir_q;
    err_d = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (err_q) begin
          if (!rx_en && !fwd_req) err_d = 1'b0;
        end else if (fwd_req) begin
          if (dir_q) st_d = ST_FWD_PE;
        end else if (rx_en) begin
          st_d = dir_q ? ST_WAIT_BYTE : ST_REV_HOLD;
        end
      end
      ST_REV_HOLD: if (expired) st_d = ST_REV_PE;
      ST_REV_PE: begin
        if (!perr_s) begin
          dir_d = 1'b1;
          st_d  = ST_WAIT_BYTE;
        end else if (expired) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_WAIT_BYTE: begin
        if (!rx_en || fwd_req) st_d = ST_IDLE;
        else if (take)         st_d = ST_WAIT_REL;
        else if (ack_s && expired) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_WAIT_REL: begin
        if (ack_s) st_d = ST_WAIT_BYTE;
        else if (expired) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_FWD_PE: begin
        if (perr_s) begin
          dir_d = 1'b0;
          st_d  = ST_IDLE;
        end else if (expired) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      dir_q <= 1'b0;
      err_q <= 1'b0;
      pin_q <= '1;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
      err_q <= err_d;
      pin_q <= pins_for(st_d, dir_d);
    end
  end

  assign host_autofd_n = pin_q.autofd_n;
  assign host_init_n   = pin_q.init_n;
  assign host_strobe_n = pin_q.strobe_n;
  assign host_selin_n  = pin_q.selin_n;
  assign link_reverse  = dir_q;
  assign link_error    = err_q;
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              fwd_req,
  input logic              host_autofd_n,
  input logic              host_init_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              link_reverse,
  input logic              link_error
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  // R2
  rev_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_reverse) |-> !host_autofd_n && !host_init_n);

  // R11
  fwd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(link_reverse) |-> host_autofd_n && host_init_n);

  // R10
  err_dir_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_error) |-> $stable(link_reverse));

  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    link_error && (rx_en || fwd_req) |=> link_error);

  // R12
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    link_error && $past(link_error) |-> $stable(host_autofd_n) && $stable(host_init_n));
endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .fwd_req(fwd_req),
  .host_autofd_n(host_autofd_n), .host_init_n(host_init_n),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .link_reverse(link_reverse), .link_error(link_error)
);

// File: tb/ecp_rev_rx_test.sv
module ecp_rev_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, fwd_req = 1'b0;
  logic per_ack_n = 1'b1, per_busy = 1'b0, per_perror = 1'b1;
  logic [7:0] per_data = 8'h00;
  logic m_ready = 1'b1;
  logic host_autofd_n, host_init_n, host_strobe_n, host_selin_n;
  logic m_valid, link_reverse, link_error;
  logic [7:0] m_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] rx_buf [64];
  int rx_cnt = 0;

  always #4 clk = ~clk;

  ecp_rev_rx uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .fwd_req(fwd_req),
    .per_ack_n(per_ack_n), .per_busy(per_busy), .per_perror(per_perror),
    .per_data(per_data),
    .host_autofd_n(host_autofd_n), .host_init_n(host_init_n),
    .host_strobe_n(host_strobe_n), .host_selin_n(host_selin_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .link_reverse(link_reverse), .link_error(link_error)
  );

  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      rx_buf[rx_cnt % 64] = m_data;
      rx_cnt++;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wait_autofd(logic lvl, int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim && !seen; i++) begin
      if (host_autofd_n === lvl) seen = 1; else step();
    end
  endtask

  // Peripheral sends one byte with a full handshake.
  task automatic send_byte(logic b, logic [7:0] v, string req);
    bit s;
    wait_autofd(1'b0, 60, s);
    per_data = v; per_busy = b;
    step();
    per_ack_n = 1'b0;
    wait_autofd(1'b1, 40, s);
    chk(s, req, host_autofd_n, 1);
    per_ack_n = 1'b1;
    wait_autofd(1'b0, 40, s);
    chk(s, req, host_autofd_n, 0);
  endtask

  task automatic t_reset();
    chk({host_autofd_n, host_init_n, host_strobe_n, host_selin_n} == 4'hF, "R1 pins",
        {host_autofd_n, host_init_n, host_strobe_n, host_selin_n}, 15);
    chk(!link_reverse && !link_error && !m_valid, "R1 flags",
        {link_reverse, link_error, m_valid}, 0);
  endtask

  task automatic t_turn_reverse();
    bit s;
    rx_en = 1'b1;
    wait_autofd(1'b0, 10, s);
    chk(s && host_init_n, "R2 autofd first, init high", host_init_n, 1);
    s = 0;
    for (int i = 0; i < 30 && !s; i++) begin
      if (!host_init_n) s = 1; else step();
    end
    chk(s, "R2 init low", host_init_n, 0);
    per_perror = 1'b0;
    s = 0;
    for (int i = 0; i < 10 && !s; i++) begin
      if (link_reverse) s = 1; else step();
    end
    chk(s, "R2 reverse", link_reverse, 1);
    chk(host_strobe_n && host_selin_n, "R2 strobe/selin high",
        {host_strobe_n, host_selin_n}, 3);
  endtask

  task automatic t_data();
    int b = rx_cnt;
    send_byte(1'b1, 8'hA5, "R5 handshake");
    send_byte(1'b1, 8'h3C, "R5 handshake");
    step(10);
    chk(rx_cnt == b + 2, "R4 count", rx_cnt - b, 2);
    chk(rx_buf[b % 64] == 8'hA5, "R4 byte0", rx_buf[b % 64], 8'hA5);
    chk(rx_buf[(b + 1) % 64] == 8'h3C, "R4 byte1", rx_buf[(b + 1) % 64], 8'h3C);
  endtask

  task automatic t_rle();
    int b = rx_cnt;
    send_byte(1'b0, 8'h03, "R7 cmd");
    send_byte(1'b1, 8'h77, "R7 data");
    send_byte(1'b1, 8'h11, "R7 data");
    step(10);
    chk(rx_cnt == b + 5, "R7 count", rx_cnt - b, 5);
    for (int i = 0; i < 4; i++)
      chk(rx_buf[(b + i) % 64] == 8'h77, "R7 repeat", rx_buf[(b + i) % 64], 8'h77);
    chk(rx_buf[(b + 4) % 64] == 8'h11, "R7 single after run", rx_buf[(b + 4) % 64], 8'h11);
  endtask

  task automatic t_channel();
    int b = rx_cnt;
    send_byte(1'b0, 8'h85, "R6 chan");
    step(10);
    chk(rx_cnt == b, "R6 no output", rx_cnt - b, 0);
    send_byte(1'b1, 8'h22, "R6 data");
    send_byte(1'b0, 8'h02, "R6 cmd");
    send_byte(1'b0, 8'h81, "R6 chan");
    send_byte(1'b1, 8'h44, "R6 data");
    step(10);
    chk(rx_cnt == b + 4, "R6 count", rx_cnt - b, 4);
    chk(rx_buf[b % 64] == 8'h22, "R6 single", rx_buf[b % 64], 8'h22);
    for (int i = 1; i < 4; i++)
      chk(rx_buf[(b + i) % 64] == 8'h44, "R6 run kept", rx_buf[(b + i) % 64], 8'h44);
  endtask

  task automatic t_backpressure();
    int b;
    bit s, stable_ok;
    m_ready = 1'b0;
    step();
    b = rx_cnt;
    send_byte(1'b0, 8'h02, "R8 cmd");
    send_byte(1'b1, 8'h5A, "R8 data");
    step(4);
    chk(m_valid && m_data == 8'h5A, "R8 valid", m_data, 8'h5A);
    stable_ok = 1;
    for (int i = 0; i < 10; i++) begin
      step();
      if (!(m_valid && m_data == 8'h5A)) stable_ok = 0;
    end
    chk(stable_ok, "R8 hold", m_data, 8'h5A);
    wait_autofd(1'b0, 60, s);
    per_data = 8'h66; per_busy = 1'b1;
    step();
    per_ack_n = 1'b0;
    step(30);
    chk(host_autofd_n == 1'b0, "R9 not taken", host_autofd_n, 0);
    m_ready = 1'b1;
    step();
    m_ready = 1'b0;
    step(5);
    chk(rx_cnt == b + 1, "R8 one pop", rx_cnt - b, 1);
    chk(host_autofd_n == 1'b0, "R9 still waiting", host_autofd_n, 0);
    m_ready = 1'b1;
    wait_autofd(1'b1, 40, s);
    chk(s, "R9 taken after drain", host_autofd_n, 1);
    per_ack_n = 1'b1;
    wait_autofd(1'b0, 40, s);
    step(10);
    chk(rx_cnt == b + 4, "R8 total", rx_cnt - b, 4);
    for (int i = 0; i < 3; i++)
      chk(rx_buf[(b + i) % 64] == 8'h5A, "R8 repeats", rx_buf[(b + i) % 64], 8'h5A);
    chk(rx_buf[(b + 3) % 64] == 8'h66, "R8 next byte", rx_buf[(b + 3) % 64], 8'h66);
  endtask

  task automatic t_release_timeout();
    bit s;
    int b = rx_cnt;
    wait_autofd(1'b0, 60, s);
    per_data = 8'h9C; per_busy = 1'b1;
    step();
    per_ack_n = 1'b0;
    wait_autofd(1'b1, 40, s);
    s = 0;
    for (int i = 0; i < 100 && !s; i++) begin
      if (link_error) s = 1; else step();
    end
    chk(s, "R10 error", link_error, 1);
    chk(link_reverse, "R10 dir kept", link_reverse, 1);
    chk(!host_autofd_n, "R10 idle pins", host_autofd_n, 0);
    step(10);
    chk(rx_cnt == b + 1, "R10 byte delivered", rx_cnt - b, 1);
    per_ack_n = 1'b1;
    step(20);
    chk(link_error && !host_autofd_n, "R12 held", link_error, 1);
    rx_en = 1'b0;
    step(3);
    chk(!link_error, "R12 cleared", link_error, 0);
  endtask

  task automatic t_turn_forward();
    bit s = 0;
    fwd_req = 1'b1;
    for (int i = 0; i < 10 && !s; i++) begin
      if (host_init_n) s = 1; else step();
    end
    chk(s && !host_autofd_n, "R11 init up, autofd low", host_autofd_n, 0);
    step(5);
    chk(link_reverse, "R11 waits", link_reverse, 1);
    per_perror = 1'b1;
    s = 0;
    for (int i = 0; i < 10 && !s; i++) begin
      if (!link_reverse) s = 1; else step();
    end
    chk(s && host_autofd_n && host_init_n, "R11 forward", {host_autofd_n, host_init_n}, 3);
    fwd_req = 1'b0;
    step(2);
  endtask

  task automatic t_turn_timeout();
    bit s = 0;
    rx_en = 1'b1;
    for (int i = 0; i < 100 && !s; i++) begin
      if (link_error) s = 1; else step();
    end
    chk(s, "R3 error", link_error, 1);
    chk(!link_reverse, "R3 dir", link_reverse, 0);
    chk(host_autofd_n && host_init_n, "R3 pins", {host_autofd_n, host_init_n}, 3);
    rx_en = 1'b0;
    step(3);
    chk(!link_error, "R12 cleared after R3", link_error, 0);
  endtask

  task automatic t_idle_timeout();
    bit s = 0;
    int n = 0;
    rx_en = 1'b1;
    for (int i = 0; i < 40 && !s; i++) begin
      if (!host_init_n) s = 1; else step();
    end
    per_perror = 1'b0;
    s = 0;
    for (int i = 0; i < 20 && !s; i++) begin
      if (link_reverse) s = 1; else step();
    end
    chk(s, "R13 reverse", link_reverse, 1);
    while (!link_error && n < 9000) begin step(); n++; end
    chk(n >= 7900 && n <= 8100, "R13 idle limit", n, 8000);
    rx_en = 1'b0;
    step(3);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(2);
    t_reset();
    t_turn_reverse();
    t_data();
    t_rle();
    t_channel();
    t_backpressure();
    t_release_timeout();
    t_turn_forward();
    t_turn_timeout();
    t_idle_timeout();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      summary();
      $finish;
    end
  end
endmodule